// File: doc/BRIEF.md
# Single-Wire Sensor Reply Emulator

This block plays the device end of a single-wire temperature and humidity sensor link. The data line is open-drain with an external pull-up: the block reads the line level on `line_i` and can only pull it low through `pull_low_o`; it never drives a high level. While idle it watches for a request from the host, which is a long low pulse. Once the host lets go of the line after such a pulse, the block sends its reply: a released gap, a low-then-high handshake, and then a frame of data bits. Each bit is coded by the length of its high period.

The frame to send comes in on `frame_i`. It is captured at the moment a valid request is recognised, so the source may change it freely while a reply is in flight. Every duration is given in microseconds and turned into clock cycles from the `CLK_HZ` parameter, rounding up. The line input passes through a two-flop synchroniser before anything looks at it. `busy_o` is high for the whole reply.

Top module: `sensor_reply_emu`

## Requirements
- R1: After a synchronous reset, and for as long as no request arrives, `pull_low_o` and `busy_o` are both 0.
- R2: Suppose the synchronised line has been low for at least ceil(CLK_HZ*500/1e6) consecutive clock samples, and then `line_i` is sampled high. Counting that sample as the first rising edge, `busy_o` rises on the third rising edge, and `frame_i` is captured on that same edge.
- R3: A host low pulse shorter than the 500 us minimum is ignored. At 1.3 MHz this means at most 649 low samples. In that case `busy_o` and `pull_low_o` stay 0.
- R4: A reply opens with 40 us released (`busy_o`=1, `pull_low_o`=0). The line is then pulled low for 80 us and released for another 80 us.
- R5: Every data bit opens with the line pulled low for 50 us.
- R6: The block sends FRAME_BITS (40) bits, starting with bit FRAME_BITS-1 and working down. After each bit's low period, the line is released for 24 us when the bit is 0 and for 68 us when the bit is 1.
- R7: The high period of the last bit is followed by 50 us of pull-low. On the edge where that pull ends, `busy_o` drops to 0 as well, and the block will then accept a new request.
- R8: Changing `frame_i` while `busy_o` is 1 has no effect on the bits of the reply already under way.
- R9: While `busy_o` is 1, whatever the host does on the line has no effect on the reply. `pull_low_o` is only ever 1 while `busy_o` is 1.
- R10: A duration of D microseconds lasts exactly ceil(CLK_HZ*D/1e6) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | FRAME_BITS (40) | Frame to send, captured when a request is recognised |
| line_i | input | 1 | Level sensed on the open-drain data line (asynchronous) |
| pull_low_o | output | 1 | 1 = enable the open-drain pull-down |
| busy_o | output | 1 | 1 while a reply is being sent |

## Verification
The bench builds the block with `CLK_HZ` = 1,300,000 and the default 40-bit frame. At this rate the 24 us and 68 us bit periods come to 31.2 and 88.4 cycles, so round-up to 32 and 89 shows directly in the cycle count, while a full reply still takes only a few thousand cycles. The 500 us request minimum comes to 650 cycles, so both sides of the glitch limit (649 and 650 low samples) are cheap to reach. The bench also drives the host low in the middle of a reply, and swaps the frame input while a reply is running.

// File: rtl/sre_pkg.sv
package sre_pkg;

    // Protocol durations in microseconds
    localparam int REQ_MIN_US = 500;
    localparam int GAP_US     = 40;
    localparam int ACK_LO_US  = 80;
    localparam int ACK_HI_US  = 80;
    localparam int BIT_LO_US  = 50;
    localparam int ZERO_HI_US = 24;
    localparam int ONE_HI_US  = 68;
    localparam int TAIL_US    = 50;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_ACK_LO,
        PH_ACK_HI,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_TAIL
    } phase_e;

    // Whole cycles covering a duration, rounded up
    function automatic int cyc_of(longint hz, int us);
        longint t;
        t = (hz * longint'(us) + 64'sd999999) / 64'sd1000000;
        return int'(t);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sre_sync.sv
module sre_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sre_req_qual.sv
module sre_req_qual #(
    parameter int MIN_C = 6000,
    localparam int CW   = $clog2(MIN_C + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          listen,
    input  logic          line,
    output logic          arm,
    output logic [CW-1:0] low_cnt
);
    // Saturating count of consecutive low samples while listening
    always_ff @(posedge clk) begin
        if (rst || !listen) begin
            low_cnt <= '0;
        end else if (!line) begin
            if (low_cnt < CW'(MIN_C))
                low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign arm = listen && line && (low_cnt >= CW'(MIN_C));
endmodule

// File: rtl/sre_phase_timer.sv
module sre_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sensor_reply_emu.sv
module sensor_reply_emu
    import sre_pkg::*;
#(
    parameter longint CLK_HZ     = 12_000_000,
    parameter int     FRAME_BITS = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  line_i,
    output logic                  pull_low_o,
    output logic                  busy_o
);
    localparam int MIN_C    = cyc_of(CLK_HZ, REQ_MIN_US);
    localparam int GAP_C    = cyc_of(CLK_HZ, GAP_US);
    localparam int ACK_LO_C = cyc_of(CLK_HZ, ACK_LO_US);
    localparam int ACK_HI_C = cyc_of(CLK_HZ, ACK_HI_US);
    localparam int BIT_LO_C = cyc_of(CLK_HZ, BIT_LO_US);
    localparam int ZERO_C   = cyc_of(CLK_HZ, ZERO_HI_US);
    localparam int ONE_C    = cyc_of(CLK_HZ, ONE_HI_US);
    localparam int TAIL_C   = cyc_of(CLK_HZ, TAIL_US);
    localparam int MAX_C    = imax(imax(imax(GAP_C, ACK_LO_C), imax(ACK_HI_C, BIT_LO_C)),
                                   imax(imax(ZERO_C, ONE_C), TAIL_C));
    localparam int TW       = $clog2(MAX_C + 1);
    localparam int CW       = $clog2(MIN_C + 1);
    localparam int BW       = $clog2(FRAME_BITS);

    logic                  line_s;
    logic                  arm;
    logic [CW-1:0]         low_cnt;
    logic                  tmr_done;
    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    phase_e                st, st_nxt;
    logic [FRAME_BITS-1:0] frame_q;
    logic [BW-1:0]         bits_left;
    logic                  capture, shift;

    sre_sync #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_i),
        .q   (line_s)
    );

    sre_req_qual #(.MIN_C(MIN_C)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .listen  (st == PH_IDLE),
        .line    (line_s),
        .arm     (arm),
        .low_cnt (low_cnt)
    );

    sre_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Phase sequencing: each phase lasts exactly its loaded length
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        shift    = 1'b0;
        case (st)
            PH_IDLE: if (arm) begin
                st_nxt   = PH_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(GAP_C - 1);
                capture  = 1'b1;
            end
            PH_GAP: if (tmr_done) begin
                st_nxt   = PH_ACK_LO;
                tmr_load = 1'b1;
                tmr_val  = TW'(ACK_LO_C - 1);
            end
            PH_ACK_LO: if (tmr_done) begin
                st_nxt   = PH_ACK_HI;
                tmr_load = 1'b1;
                tmr_val  = TW'(ACK_HI_C - 1);
            end
            PH_ACK_HI: if (tmr_done) begin
                st_nxt   = PH_BIT_LO;
                tmr_load = 1'b1;
                tmr_val  = TW'(BIT_LO_C - 1);
            end
            PH_BIT_LO: if (tmr_done) begin
                st_nxt   = PH_BIT_HI;
                tmr_load = 1'b1;
                tmr_val  = frame_q[FRAME_BITS-1] ? TW'(ONE_C - 1) : TW'(ZERO_C - 1);
            end
            PH_BIT_HI: if (tmr_done) begin
                shift    = 1'b1;
                tmr_load = 1'b1;
                if (bits_left == '0) begin
                    st_nxt  = PH_TAIL;
                    tmr_val = TW'(TAIL_C - 1);
                end else begin
                    st_nxt  = PH_BIT_LO;
                    tmr_val = TW'(BIT_LO_C - 1);
                end
            end
            PH_TAIL: if (tmr_done) st_nxt = PH_IDLE;
            default: st_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_IDLE;
            frame_q   <= '0;
            bits_left <= '0;
        end else begin
            st <= st_nxt;
            if (capture) begin
                frame_q   <= frame_i;
                bits_left <= BW'(FRAME_BITS - 1);
            end else if (shift) begin
                frame_q   <= {frame_q[FRAME_BITS-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    assign pull_low_o = (st == PH_ACK_LO) || (st == PH_BIT_LO) || (st == PH_TAIL);
    assign busy_o     = (st != PH_IDLE);
endmodule

// File: rtl/sre_checker.sv
module sre_checker
    import sre_pkg::*;
#(
    parameter longint CLK_HZ = 12_000_000,
    localparam int MIN_C    = cyc_of(CLK_HZ, REQ_MIN_US),
    localparam int CW       = $clog2(MIN_C + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          pull_low_o,
    input logic          busy_o,
    input logic [CW-1:0] low_cnt
);
    localparam int GAP_C    = cyc_of(CLK_HZ, GAP_US);
    localparam int ACK_LO_C = cyc_of(CLK_HZ, ACK_LO_US);
    localparam int ACK_HI_C = cyc_of(CLK_HZ, ACK_HI_US);
    localparam int BIT_LO_C = cyc_of(CLK_HZ, BIT_LO_US);
    localparam int ZERO_C   = cyc_of(CLK_HZ, ZERO_HI_US);
    localparam int ONE_C    = cyc_of(CLK_HZ, ONE_HI_US);
    localparam int TAIL_C   = cyc_of(CLK_HZ, TAIL_US);

    int lo_run;
    int rel_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run  <= 0;
            rel_run <= 0;
        end else begin
            lo_run  <= pull_low_o ? lo_run + 1 : 0;
            rel_run <= (busy_o && !pull_low_o) ? rel_run + 1 : 0;
        end
    end

    p_pull_only_busy_r9: assert property (@(posedge clk) disable iff (rst)
        pull_low_o |-> busy_o);

    p_arm_needs_long_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(low_cnt) >= CW'(MIN_C)));

    p_pull_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_low_o) |-> (lo_run == ACK_LO_C || lo_run == BIT_LO_C || lo_run == TAIL_C));

    p_release_len_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low_o) |->
            (rel_run == GAP_C || rel_run == ACK_HI_C || rel_run == ZERO_C || rel_run == ONE_C));

    p_end_after_tail_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> ($past(pull_low_o) && lo_run == TAIL_C));
endmodule

bind sensor_reply_emu sre_checker #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pull_low_o (pull_low_o),
    .busy_o     (busy_o),
    .low_cnt    (low_cnt)
);

// File: tb/sensor_reply_emu_bench.sv
module sensor_reply_emu_bench;
    localparam longint HZ = 1_300_000;
    localparam int     NB = 40;

    function automatic int cyc(int us);
        longint t;
        t = (HZ * longint'(us) + 64'sd999999) / 64'sd1000000;
        return int'(t);
    endfunction

    localparam int C_MIN   = cyc(500);
    localparam int C_GAP   = cyc(40);
    localparam int C_ACKLO = cyc(80);
    localparam int C_ACKHI = cyc(80);
    localparam int C_BITLO = cyc(50);
    localparam int C_ZERO  = cyc(24);
    localparam int C_ONE   = cyc(68);
    localparam int C_TAIL  = cyc(50);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_low = 1'b0;
    logic [NB-1:0] frame = '0;
    logic          line;
    logic          pull, busy;

    // Wired-AND open-drain line with pull-up
    assign line = ~(host_low | pull);

    always #10 clk = ~clk;

    sensor_reply_emu #(.CLK_HZ(HZ), .FRAME_BITS(NB)) u_sensor_reply_emu (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame),
        .line_i     (line),
        .pull_low_o (pull),
        .busy_o     (busy)
    );

    int vectors = 0;
    int miscmp  = 0;

    // Reference model state
    bit    m_busy = 1'b0;
    bit    m_pull = 1'b0;
    string m_tag  = "R1";
    string idle_tag = "R1";
    string note = "";
    int    run = 0;
    bit    lagq[$];
    bit    qp[$];
    string qt[$];

    task automatic push_n(input bit p, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            qp.push_back(p);
            qt.push_back(tag);
        end
    endtask

    task automatic build(input logic [NB-1:0] f);
        push_n(1'b0, C_GAP, "R4");
        qt[0] = "R2";
        push_n(1'b1, C_ACKLO, "R4");
        push_n(1'b0, C_ACKHI, "R4");
        for (int i = NB - 1; i >= 0; i--) begin
            push_n(1'b1, C_BITLO, "R5/R10");
            push_n(1'b0, f[i] ? C_ONE : C_ZERO, "R6/R10");
        end
        push_n(1'b1, C_TAIL, "R7");
    endtask

    task automatic model(input bit l);
        bit v;
        lagq.push_back(l);
        v = lagq.pop_front();
        if (m_busy) begin
            if (qp.size() > 0) begin
                m_pull = qp.pop_front();
                m_tag  = qt.pop_front();
            end else begin
                m_busy = 1'b0;
                m_pull = 1'b0;
                m_tag  = idle_tag;
            end
        end else begin
            m_tag = idle_tag;
            if (!v) begin
                if (run < C_MIN) run++;
            end else if (run >= C_MIN) begin
                build(frame);
                m_busy = 1'b1;
                m_pull = qp.pop_front();
                m_tag  = qt.pop_front();
                run    = 0;
            end else begin
                run = 0;
            end
        end
    endtask

    // Called at a falling edge; applies one clock and compares
    task automatic step(input bit hl);
        bit l;
        host_low = hl;
        l = ~(hl | m_pull);
        @(posedge clk);
        @(negedge clk);
        model(l);
        vectors++;
        if (pull !== m_pull || busy !== m_busy) begin
            miscmp++;
            $display("FAIL %s%s: pull_low_o=%b busy_o=%b expected pull_low_o=%b busy_o=%b",
                     m_tag, note, pull, busy, m_pull, m_busy);
        end
    endtask

    task automatic finish_reply();
        repeat (5) step(1'b0);
        while (m_busy) step(1'b0);
    endtask

    initial begin
        lagq.push_back(1'b1);
        lagq.push_back(1'b1);
        repeat (4) @(negedge clk);
        // R1: outputs idle under reset
        vectors++;
        if (pull !== 1'b0 || busy !== 1'b0) begin
            miscmp++;
            $display("FAIL R1: pull_low_o=%b busy_o=%b expected 0 0", pull, busy);
        end
        rst = 1'b0;

        idle_tag = "R1";
        repeat (20) step(1'b0);

        // R3: low one sample short of the minimum, then a short glitch
        idle_tag = "R3";
        repeat (C_MIN - 1) step(1'b1);
        repeat (30) step(1'b0);
        repeat (10) step(1'b1);
        repeat (30) step(1'b0);

        // R2: exactly the minimum low, mixed frame
        idle_tag = "R2";
        frame = 40'hA5_3C_0F_F0_81;
        repeat (C_MIN) step(1'b1);
        finish_reply();
        idle_tag = "R7";
        repeat (20) step(1'b0);

        // R8 and R9: all-ones frame, input swapped and host noise mid-reply
        idle_tag = "R7";
        frame = '1;
        repeat (2 * C_MIN) step(1'b1);
        repeat (200) step(1'b0);
        note  = " R8";
        frame = '0;
        repeat (200) step(1'b0);
        note = " R9";
        repeat (7) step(1'b1);
        note = " R8";
        finish_reply();
        note = "";
        repeat (20) step(1'b0);

        // R6: msb and lsb set, zeros between
        frame = 40'h80_0000_0001;
        repeat (C_MIN + 3) step(1'b1);
        finish_reply();
        repeat (20) step(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscmp++;
        $display("FAIL R7: watchdog expired, busy_o=%b expected a finished run", busy);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule